// File: doc/BRIEF.md
# Burn-in Stimulus Generator

This block drives the repeating stimulus pattern used to exercise a processor during dynamic burn-in. A single synchronous counter advances on a base-rate enable and feeds a set of halved square-wave taps, so every tap, pulse and level changes on the same clock edge and none skews against another. Three window decoders look at the counter's next value and produce a ready stimulus locked to one tap, a reset pulse and an interrupt pulse. A slow mode-select square wave is taken straight from the counter's top bit.

`base_tick` marks every edge of the base square wave, meaning each half of one base period. The unit time T is one base period, which is two ticks. All pulse widths and repeat rates come from fixed positions in the counter rather than from programmed values. The reset pulse sits a quarter of the way into each repeat frame and the interrupt pulse sits three quarters of the way in, so the two can never be high together.

Top module: `burnin_stim_gen`

## Requirements
- R1: While `rst` is sampled high on a clock edge, every output is low after that edge, and after `rst` is released the tick count n starts again from zero.
- R2: On an edge where `base_tick` is low, no output changes.
- R3: Bit i-1 of `div_taps_o` (tap i, i = 1..STAGES) equals bit i of the tick count n. Every tap updates on the edge that samples the tick.
- R4: `rst_stim_o` is high exactly when (n mod 2^(STAGES+2)) lies in [2^STAGES, 2^STAGES + 16). This is a pulse 8T wide, repeated once every two periods of the slowest tap.
- R5: `nmi_stim_o` is high exactly when (n mod 2^(STAGES+2)) lies in [3*2^STAGES, 3*2^STAGES + 8). This is a pulse 4T wide with the same repeat rate as R4.
- R6: `rst_stim_o` and `nmi_stim_o` are never high together.
- R7: `rdy_stim_o` is high exactly when (n mod 2^(RDY_TAP+1)) lies in [2^RDY_TAP, 2^RDY_TAP + 8). This is a 4T pulse that starts at each rising edge of tap RDY_TAP.
- R8: `mode_sel_o` equals bit STAGES+4 of n. It is a 50% square wave that changes level once every eight periods of the slowest tap, and at each change all taps are low.
- R9: Asserting `rst` mid-run restarts the whole pattern from tick count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable at each edge of the base square wave |
| div_taps_o | output | STAGES (16) | Halved square waves, bit 0 = first division |
| rdy_stim_o | output | 1 | Ready stimulus pulse locked to tap RDY_TAP |
| rst_stim_o | output | 1 | Periodic reset stimulus pulse, 8T wide |
| nmi_stim_o | output | 1 | Periodic interrupt stimulus pulse, 4T wide |
| mode_sel_o | output | 1 | Slow mode-select square wave |

## Verification
All outputs are set by one tick count, so a wrong count shows up at once on the low taps and makes them disagree with the reference on the next edge. A fault in a window decoder only shows while its window passes. The reset window and the interrupt window each come up once per frame, so those faults need up to one full frame of ticks to appear. The ready window repeats every 2^(RDY_TAP+1) ticks. The mode level is only exposed when the count crosses bit STAGES+4. For that reason the bench uses a reduced STAGES and runs past two mode changes, with gaps in the tick stream.

// File: rtl/burnin_pkg.sv
package burnin_pkg;
  // Ticks per unit time T: one tick per base-wave edge.
  localparam int unsigned TICKS_PER_T = 2;

  function automatic logic win_hit(input int unsigned ph,
                                   input int unsigned start,
                                   input int unsigned len);
    return (ph >= start) && (ph < start + len);
  endfunction
endpackage

// File: rtl/bi_div_chain.sv
module bi_div_chain #(
  parameter int unsigned STAGES     = 16,
  parameter int unsigned CW         = 21,
  parameter int unsigned FRAME_BITS = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  output logic [STAGES-1:0]     taps_o,
  output logic                  mode_o,
  output logic [FRAME_BITS-1:0] phase_nxt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb cnt_nxt = tick_i ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_tap
      assign taps_o[gi] = cnt_q[gi+1];
    end
  endgenerate

  assign mode_o      = cnt_q[CW-1];
  assign phase_nxt_o = rst ? '0 : cnt_nxt[FRAME_BITS-1:0];

  // R2: count holds without a tick
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));
  // R3: second tap rises only when first tap falls on the same edge
  a_r3_same_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(taps_o[1]) |-> $fell(taps_o[0]));
endmodule

// File: rtl/bi_window_pulse.sv
module bi_window_pulse
  import burnin_pkg::*;
#(
  parameter int unsigned PHASE_BITS = 6,
  parameter int unsigned START      = 32,
  parameter int unsigned LEN        = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PHASE_BITS-1:0] phase_nxt_i,
  output logic                  pulse_o
);
  int unsigned ph;
  logic        hit;

  always_comb begin
    ph  = 32'(phase_nxt_i);
    hit = win_hit(ph, START, LEN);
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= hit;
  end
endmodule

// File: rtl/burnin_stim_gen.sv
module burnin_stim_gen
  import burnin_pkg::*;
#(
  parameter int unsigned STAGES         = 16,
  parameter int unsigned RST_LEN_T      = 8,
  parameter int unsigned NMI_LEN_T      = 4,
  parameter int unsigned RDY_TAP        = 5,
  parameter int unsigned RDY_LEN_T      = 4,
  parameter int unsigned MODE_SPAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  output logic [STAGES-1:0] div_taps_o,
  output logic              rdy_stim_o,
  output logic              rst_stim_o,
  output logic              nmi_stim_o,
  output logic              mode_sel_o
);
  localparam int unsigned FRAME_BITS = STAGES + 2;
  localparam int unsigned CW         = STAGES + 2 + MODE_SPAN_LOG2;
  localparam int unsigned RST_START  = 1 << STAGES;
  localparam int unsigned NMI_START  = 3 << STAGES;
  localparam int unsigned RDY_BITS   = RDY_TAP + 1;
  localparam int unsigned RDY_START  = 1 << RDY_TAP;

  logic [FRAME_BITS-1:0] phase_nxt;

  bi_div_chain #(.STAGES(STAGES), .CW(CW), .FRAME_BITS(FRAME_BITS)) u_div (
    .clk(clk), .rst(rst), .tick_i(base_tick),
    .taps_o(div_taps_o), .mode_o(mode_sel_o), .phase_nxt_o(phase_nxt)
  );

  bi_window_pulse #(.PHASE_BITS(FRAME_BITS), .START(RST_START),
                    .LEN(RST_LEN_T*TICKS_PER_T)) u_rst_win (
    .clk(clk), .rst(rst), .phase_nxt_i(phase_nxt), .pulse_o(rst_stim_o)
  );

  bi_window_pulse #(.PHASE_BITS(FRAME_BITS), .START(NMI_START),
                    .LEN(NMI_LEN_T*TICKS_PER_T)) u_nmi_win (
    .clk(clk), .rst(rst), .phase_nxt_i(phase_nxt), .pulse_o(nmi_stim_o)
  );

  bi_window_pulse #(.PHASE_BITS(RDY_BITS), .START(RDY_START),
                    .LEN(RDY_LEN_T*TICKS_PER_T)) u_rdy_win (
    .clk(clk), .rst(rst), .phase_nxt_i(phase_nxt[RDY_BITS-1:0]), .pulse_o(rdy_stim_o)
  );

  // R1: everything low after a reset edge
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (div_taps_o == '0 && !rdy_stim_o && !rst_stim_o &&
                    !nmi_stim_o && !mode_sel_o));
  // R6: the two pulses never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rst_stim_o && nmi_stim_o));
  // R4: reset pulse only begins on a tick edge
  a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_stim_o) |-> $past(base_tick));
  // R8: mode level changes only where all taps wrap to zero
  a_r8_mode_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_sel_o) |-> (div_taps_o == '0));
endmodule

// File: tb/sim_burnin_stim_gen.sv
`timescale 1ns/1ps
module sim_burnin_stim_gen;
  localparam int S = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [S-1:0] taps;
  logic rdy, rs, nmi, mode;

  int n = 0;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic last_tick = 1'b0;
  logic last_rst = 1'b1;
  logic checking = 1'b0;
  logic [S-1:0] prev_taps = '0;

  always #10 clk = ~clk;

  burnin_stim_gen #(.STAGES(S)) u0 (
    .clk(clk), .rst(rst), .base_tick(tick), .div_taps_o(taps),
    .rdy_stim_o(rdy), .rst_stim_o(rs), .nmi_stim_o(nmi), .mode_sel_o(mode)
  );

  // Behavioural tick count
  always @(posedge clk) begin
    last_tick <= tick;
    last_rst  <= rst;
    if (rst) n <= 0;
    else if (tick) n <= n + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s n=%0d actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic int in_win(input int ph, input int st, input int len);
    return (ph >= st && ph < st + len) ? 1 : 0;
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      int fr, exp_taps;
      fr = n % (1 << (S+2));
      exp_taps = (n >> 1) & ((1 << S) - 1);
      if (last_rst) begin
        chk("R1 taps", int'(taps), 0);
        chk("R1 pulses", int'({rdy, rs, nmi, mode}), 0);
      end else begin
        chk("R3 taps", int'(taps), exp_taps);
        if (!last_tick) chk("R2 hold", int'(taps), int'(prev_taps));
        chk("R4 rst pulse", int'(rs), in_win(fr, 1 << S, 16));
        chk("R5 nmi pulse", int'(nmi), in_win(fr, 3 << S, 8));
        chk("R6 overlap", int'(rs & nmi), 0);
        chk("R7 ready", int'(rdy), in_win(n % 64, 32, 8));
        chk("R8 mode", int'(mode), (n >> (S+4)) & 1);
      end
      prev_taps = taps;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checking = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // gapped tick stream, one idle cycle in seven (R2)
    for (int i = 0; i < 20000; i++) begin
      tick = (i % 7) != 6;
      @(negedge clk);
    end
    // mid-run reset (R9)
    tick = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 restart taps", int'(taps), 0);
    for (int i = 0; i < 36000; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule